// File: doc/BRIEF.md
# Interleaved Block Fetch Engine

This block fills one cache line from four word-interleaved memory banks. A miss arrives as a block address on a valid/ready handshake. The engine holds the address for one cycle. It then starts a read in all four banks at once. Each bank is a fixed-latency pipeline that is modelled inside the block. When the banks finish together, the engine returns the four words of the block over a single-word bus, one word per cycle, lowest word first, and flags the final word.

Because the four bank accesses overlap, a fill costs one address cycle, then one bank access time, then one cycle per word: 11 cycles with the default six-cycle banks. Fetching one word at a time from a single bank would take 32 cycles. A separate write port loads bank storage directly, so that contents can be placed before a fill.

Top module: `ilv_fill_engine`

## Requirements
- R1: After reset, `req_ready` is high while the engine is idle. A request is taken on a rising edge where both `req_valid` and `req_ready` are high. `req_blk` names a block of four consecutive words.
- R2: Word address bits [1:0] pick the bank, and bits [ADDR_W-1:2] pick the row inside that bank. Word w of a block comes from bank w.
- R3: All four banks begin their read in the same cycle, which is the cycle after the accepting edge. All four finish in the same cycle.
- R4: Take the accepting edge as edge k. Word i of the block is on `rsp_data` from edge k+6+i until edge k+7+i. Counting the request cycle as cycle 1, the first word is therefore in cycle 8 and the last in cycle 11.
- R5: The words come out on consecutive cycles in ascending order 0, 1, 2, 3. `rsp_valid` is high for exactly four cycles per request.
- R6: `rsp_last` is high with word 3 and in no other cycle.
- R7: `req_ready` is low from the accepting edge to the end of the last-word cycle, and high again in the next cycle. While `req_ready` is low, `req_valid` is ignored: no extra words appear.
- R8: When `wr_en` is high on a rising edge, `wr_data` is stored at word address `wr_addr`. A later fill of that block returns the stored value.
- R9: While reset is applied and just after it, `req_ready` is 1, `rsp_valid` is 0 and `rsp_last` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Fill request valid |
| req_blk | input | ADDR_W-2 | Block address of the fill |
| req_ready | output | 1 | Engine idle; a request can be taken |
| wr_en | input | 1 | Direct storage write strobe |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Write data |
| rsp_valid | output | 1 | A block word is on `rsp_data` |
| rsp_data | output | DATA_W | Returned word |
| rsp_last | output | 1 | Final word of the block |

## Verification
The assertions are checked on every cycle, and they cover the cycle-level structure of a fill:
- all banks finish together, and the first returned word coincides with their completion (R3);
- the first word appears exactly six edges after acceptance (R4);
- the word index steps by one without gaps (R5);
- `rsp_last` ends the stream (R6);
- ready returns in the cycle after the last word (R7).

Only the bench's scenarios can show the rest:
- that the returned data really comes from the right bank and row (R2);
- that written data comes back (R8);
- that requests held during a fill are ignored (R7);
- the exact edge of every word across back-to-back fills (R4).

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int unsigned BANKS  = 4;
  localparam int unsigned BSEL_W = $clog2(BANKS);

  typedef enum logic [1:0] {
    FE_IDLE = 2'd0,
    FE_WAIT = 2'd1,
    FE_SEND = 2'd2
  } fe_state_e;
endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int unsigned ROW_W  = 6,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LAT    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_go,
  input  logic [ROW_W-1:0]  rd_row,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_done
);
  localparam int unsigned ROWS = 2 ** ROW_W;

  logic [DATA_W-1:0] mem [ROWS];
  logic [DATA_W-1:0] stg_d [LAT];
  logic [LAT-1:0]    stg_v, stg_v_nxt;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_row] <= wr_data;
  end

  // data stages only move behind a valid token, so the last stage holds its word
  always_ff @(posedge clk) begin
    if (rd_go) stg_d[0] <= mem[rd_row];
    for (int j = 1; j < LAT; j++) begin
      if (stg_v[j-1]) stg_d[j] <= stg_d[j-1];
    end
  end

  always_comb stg_v_nxt = {stg_v[LAT-2:0], rd_go};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_v <= '0;
    else        stg_v <= stg_v_nxt;
  end

  assign rd_data = stg_d[LAT-1];
  assign rd_done = stg_v[LAT-1];

  // R3: a read in flight is never restarted before it completes
  a_r3_single_flight: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |-> (stg_v == '0));
endmodule

// File: rtl/ilv_seq.sv
module ilv_seq
  import ilv_pkg::*;
#(
  parameter int unsigned LAT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  output logic              accept,
  output logic              launch,
  output logic              rsp_valid,
  output logic              rsp_last,
  output logic [BSEL_W-1:0] word_sel
);
  localparam int unsigned CNT_W = (LAT > 2) ? $clog2(LAT) : 1;
  localparam logic [CNT_W-1:0]  CNT_END  = CNT_W'(LAT - 1);
  localparam logic [BSEL_W-1:0] WSEL_END = BSEL_W'(BANKS - 1);

  fe_state_e         st_q, st_nxt;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic [BSEL_W-1:0] wsel_q, wsel_nxt;

  always_comb begin
    st_nxt   = st_q;
    cnt_nxt  = cnt_q;
    wsel_nxt = wsel_q;
    accept   = 1'b0;
    launch   = 1'b0;
    unique case (st_q)
      FE_IDLE: begin
        if (req_valid) begin
          accept  = 1'b1;
          st_nxt  = FE_WAIT;
          cnt_nxt = '0;
        end
      end
      FE_WAIT: begin
        launch = (cnt_q == '0);
        if (cnt_q == CNT_END) begin
          st_nxt   = FE_SEND;
          wsel_nxt = '0;
        end else begin
          cnt_nxt = cnt_q + 1'b1;
        end
      end
      FE_SEND: begin
        if (wsel_q == WSEL_END) st_nxt = FE_IDLE;
        else                    wsel_nxt = wsel_q + 1'b1;
      end
      default: st_nxt = FE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FE_IDLE;
      cnt_q  <= '0;
      wsel_q <= '0;
    end else begin
      st_q   <= st_nxt;
      cnt_q  <= cnt_nxt;
      wsel_q <= wsel_nxt;
    end
  end

  assign req_ready = (st_q == FE_IDLE);
  assign rsp_valid = (st_q == FE_SEND);
  assign rsp_last  = rsp_valid && (wsel_q == WSEL_END);
  assign word_sel  = wsel_q;

  a_r5_word_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_last) |=> (rsp_valid && word_sel == $past(word_sel) + 1'b1));
  a_r6_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |=> !rsp_valid);
  a_r7_ready_back: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |=> req_ready);
  a_r7_no_take_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !accept);
endmodule

// File: rtl/ilv_fill_engine.sv
module ilv_fill_engine
  import ilv_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned BANK_LAT = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [ADDR_W-BSEL_W-1:0] req_blk,
  output logic                     req_ready,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_data,
  output logic                     rsp_last
);
  localparam int unsigned ROW_W = ADDR_W - BSEL_W;

  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  logic              accept, launch;
  logic [BSEL_W-1:0] word_sel;
  logic [ROW_W-1:0]  row_q;
  logic [BANKS-1:0][DATA_W-1:0] bank_data;
  logic [BANKS-1:0]  bank_done;

  ilv_seq #(.LAT(BANK_LAT)) u_seq (
    .clk       (clk),
    .rst_n     (rst_s2),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .accept    (accept),
    .launch    (launch),
    .rsp_valid (rsp_valid),
    .rsp_last  (rsp_last),
    .word_sel  (word_sel)
  );

  // address send cycle: block row captured on the accepting edge
  always_ff @(posedge clk) begin
    if (accept) row_q <= req_blk;
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic wr_hit;
    assign wr_hit = wr_en && (wr_addr[BSEL_W-1:0] == BSEL_W'(b));
    ilv_bank #(.ROW_W(ROW_W), .DATA_W(DATA_W), .LAT(BANK_LAT)) u_bank (
      .clk     (clk),
      .rst_n   (rst_s2),
      .wr_en   (wr_hit),
      .wr_row  (wr_addr[ADDR_W-1:BSEL_W]),
      .wr_data (wr_data),
      .rd_go   (launch),
      .rd_row  (row_q),
      .rd_data (bank_data[b]),
      .rd_done (bank_done[b])
    );
  end

  assign rsp_data = bank_data[word_sel];

  // checker support: edges since the last acceptance, saturating
  logic [7:0] since_acc;
  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2)               since_acc <= 8'hFF;
    else if (accept)           since_acc <= '0;
    else if (since_acc != 8'hFF) since_acc <= since_acc + 1'b1;
  end

  a_r3_banks_together: assert property (@(posedge clk) disable iff (!rst_s2)
    bank_done[0] |-> (&bank_done));
  a_r3_first_on_done: assert property (@(posedge clk) disable iff (!rst_s2)
    $rose(rsp_valid) |-> bank_done[0]);
  a_r4_first_latency: assert property (@(posedge clk) disable iff (!rst_s2)
    $rose(rsp_valid) |-> (since_acc == 8'(BANK_LAT)));
endmodule

// File: tb/tb_ilv_fill_engine.sv
module tb_ilv_fill_engine;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int BW = AW - 2;

  logic clk = 1'b0;
  logic rst_n, req_valid, req_ready, wr_en, rsp_valid, rsp_last;
  logic [BW-1:0] req_blk;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data, rsp_data;

  always #5 clk = ~clk;

  ilv_fill_engine #(.ADDR_W(AW), .DATA_W(DW), .BANK_LAT(6)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_blk(req_blk),
    .req_ready(req_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last));

  int n_chk = 0, n_fail = 0, edge_no = 0;
  bit mon_en = 0, want_ready = 0;
  logic [DW-1:0] model [2**AW];
  logic [DW-1:0] q_data [$];
  int            q_edge [$];
  bit            q_last [$];

  always @(posedge clk) edge_no++;

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a word is presented
  always @(negedge clk) begin
    if (mon_en) begin
      if (want_ready) begin
        chk(req_ready == 1'b1, "R7", "ready after last word", req_ready, 1);
        want_ready = 0;
      end
      if (rsp_valid) begin
        if (q_data.size() == 0) begin
          chk(1'b0, "R7", "unexpected word", 1, 0);
        end else begin
          logic [DW-1:0] d;
          int e;
          bit l;
          d = q_data.pop_front();
          e = q_edge.pop_front();
          l = q_last.pop_front();
          chk(rsp_data == d, "R2,R5", "word data", rsp_data, d);
          chk(edge_no == e, "R3,R4", "word edge", edge_no, e);
          chk(rsp_last == l, "R6", "last flag", rsp_last, l);
          chk(req_ready == 1'b0, "R7", "ready during stream", req_ready, 0);
          if (l) want_ready = 1;
        end
      end
    end
  end

  task automatic write_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
    model[a] = d;
  endtask

  // driver: issues a fill and pushes the expected words (R1, R4 timing)
  task automatic fetch(input logic [BW-1:0] blk, input bit junk);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_blk = blk;
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      q_data.push_back(model[{blk, 2'(i)}]);
      q_edge.push_back(edge_no + 6 + i);
      q_last.push_back(i == 3);
    end
    if (junk) begin
      req_blk = ~blk;
      repeat (8) @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (q_data.size() != 0 || !req_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R5 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_blk = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R9", "ready in reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R9", "valid in reset", rsp_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "idle ready", req_ready, 1);
    chk(rsp_valid == 1'b0, "R9", "valid after reset", rsp_valid, 0);
    chk(rsp_last == 1'b0, "R9", "last after reset", rsp_last, 0);
    mon_en = 1;

    // R8: preload every word with a distinct pattern
    for (int a = 0; a < 2**AW; a++)
      write_word(AW'(a), 32'h1000_0000 + DW'(a) * 32'h0001_0003);

    fetch(6'd0, 1'b0);
    fetch(6'd5, 1'b0);           // back-to-back, taken the cycle ready returns
    fetch(6'd63, 1'b1);          // R7: request held while busy is ignored
    drain();

    // R8: overwrite words of block 7 in banks 1 and 2, then fetch
    write_word({6'd7, 2'd2}, 32'hDEAD_BEEF);
    write_word({6'd7, 2'd1}, 32'h0BAD_F00D);
    fetch(6'd7, 1'b0);
    fetch(6'd42, 1'b0);
    drain();

    chk(q_data.size() == 0, "R5", "all words delivered", q_data.size(), 0);
    chk(rsp_valid == 1'b0, "R7", "no stray words", rsp_valid, 0);
    finish_run();
  end
endmodule